// File: doc/BRIEF.md
# Partitioned Pixel Pack and Format Unit

This block is the pixel-formatting slice of a SIMD media datapath. Each cycle it takes an operation code, two 64-bit source operands and an 8-bit format-control byte. From these it produces one formatted result. Three of its operations narrow wide lanes to pixel bytes or 16-bit fixed-point values. Each of these multiplies a lane by a programmable power of two, divides it by a fixed power of two that depends on the operation, and then clamps the value. The other two operations widen bytes to fixed point or interleave the bytes of two words.

The register file and the status register that supplies the control byte are outside the block. A caller presents `in_valid` together with the operands. With the default `REG_OUT = 1`, the result appears on `out_valid`/`result` one clock later. With `REG_OUT = 0` the path is purely combinational. Narrow results are returned zero-extended in the low 32 bits of `result`.

Top module: `pxfmt_unit`

## Requirements
- R1: Exactly five operation codes are accepted: 0x03B (pack16), 0x03A (pack32), 0x03D (packfix), 0x04D (expand) and 0x04B (merge).
- R2: An `in_valid` cycle carrying any other code yields `out_valid` = 0 and `result` = 0 in the following cycle.
- R3: Pack16 reads `src_b` as four signed 16-bit lanes. It uses the scale in `fmt_ctrl[6:3]` and ignores `fmt_ctrl[7]` and `fmt_ctrl[2:0]`. Each lane is computed as floor(lane × 2^scale / 128), clamped to 0..255, and written to byte i of `result`. Bits 63:32 are 0.
- R4: Pack32 reads `src_b` as two signed 32-bit lanes with the scale in `fmt_ctrl[7:3]`. Lane i becomes floor(lane × 2^scale / 2^23), clamped to 0..255, and is written to bits 32i+7..32i of `result`.
- R5: For pack32, `result[31:8]` = `src_a[23:0]` and `result[63:40]` = `src_a[55:32]`. This is the first operand shifted up one byte, with the two vacated bytes taken by the R4 values.
- R6: Packfix reads `src_b` as two signed 32-bit lanes with the scale in `fmt_ctrl[7:3]`. Lane i becomes floor(lane × 2^scale / 65536), saturated to -32768..32767, and is written to `result[16i+15:16i]`. Bits 63:32 are 0.
- R7: Expand places byte k of `src_b[31:0]`, zero-extended and multiplied by 16, into 16-bit lane k of `result`.
- R8: Merge writes byte k of `src_b` to `result` byte 2k and byte k of `src_a` to `result` byte 2k+1, for k = 0..3.
- R9: Clamping is exact at every scale, including the largest. No intermediate wraps before the clamp, so a positive lane never clamps low and a negative lane never clamps high.
- R10: With `REG_OUT = 1`, `out_valid` rises exactly one cycle after an accepted `in_valid`. It is 0 in the cycle after `in_valid` is low, and `result` is then 0.
- R11: While `rst_n` is low at a clock edge, `out_valid` and `result` are cleared in the next cycle. The reset is synchronous and active low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operands and code are valid this cycle |
| op_code | input | 9 | Operation selector |
| src_a | input | 64 | First operand (pack32 stream, merge high bytes) |
| src_b | input | 64 | Second operand (lanes to pack, expand/merge low bytes) |
| fmt_ctrl | input | 8 | Format control; scale in bits 7:3 |
| out_valid | output | 1 | Result is valid |
| result | output | 64 | Formatted result |

## Verification
The hardest case to reach is a lane whose scaled value would wrap a narrower intermediate. An example is a pack32 lane of 0x7FFFFFFF at scale 31, which must still clamp to the top of the range and not flip sign. The stimulus reaches it by sweeping every scale value against a fixed set of boundary lane words: the largest positive, the most negative, ±1, and the values on either side of each clamp threshold. Every lane pattern is rotated through every lane position. In the pack16 sweep, control bit 7 and the low bits are set to junk, so that the narrower 4-bit scale field is exercised as well.

// File: rtl/pxfmt_pkg.sv
package pxfmt_pkg;

  localparam logic [8:0] OPC_PACK16  = 9'h03B;
  localparam logic [8:0] OPC_PACK32  = 9'h03A;
  localparam logic [8:0] OPC_PACKFIX = 9'h03D;
  localparam logic [8:0] OPC_EXPAND  = 9'h04D;
  localparam logic [8:0] OPC_MERGE   = 9'h04B;

  typedef enum logic [2:0] {
    K_NONE, K_PACK16, K_PACK32, K_PACKFIX, K_EXPAND, K_MERGE
  } fmt_kind_e;

  // Clamp a wide signed value to an unsigned pixel byte.
  function automatic logic [7:0] clamp_u8(input logic signed [63:0] v);
    if (v < 64'sd0)        return 8'h00;
    else if (v > 64'sd255) return 8'hFF;
    else                   return v[7:0];
  endfunction

  // Saturate a wide signed value to a signed 16-bit word.
  function automatic logic [15:0] clamp_s16(input logic signed [63:0] v);
    if (v < -64'sd32768)     return 16'h8000;
    else if (v > 64'sd32767) return 16'h7FFF;
    else                     return v[15:0];
  endfunction

  // Programmable left scale followed by a fixed arithmetic right shift.
  function automatic logic signed [63:0] rescale(input logic signed [63:0] v,
                                                 input logic [4:0] lsh,
                                                 input int unsigned rsh);
    logic signed [63:0] up;
    up = v <<< lsh;
    return up >>> rsh;
  endfunction

endpackage

// File: rtl/pxfmt_pack16.sv
module pxfmt_pack16 #(
  parameter int LANES   = 4,
  parameter int LANE_W  = 16,
  parameter int FRAC_SH = 7
) (
  input  logic [LANES*LANE_W-1:0] src,
  input  logic [3:0]              scale,
  output logic [LANES*8-1:0]      pk_out,
  output logic [LANES-1:0]        clip_hi,
  output logic [LANES-1:0]        clip_lo
);
  localparam int WIDE_W = 3 * LANE_W;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic signed [WIDE_W-1:0] wide;
    logic signed [WIDE_W-1:0] lifted;
    logic signed [WIDE_W-1:0] shifted;

    assign wide    = WIDE_W'($signed(src[i*LANE_W +: LANE_W]));
    assign lifted  = wide <<< scale;
    assign shifted = lifted >>> FRAC_SH;

    assign clip_lo[i] = shifted[WIDE_W-1];
    assign clip_hi[i] = !shifted[WIDE_W-1] && (shifted[WIDE_W-2:8] != '0);

    assign pk_out[i*8 +: 8] = clip_hi[i] ? 8'hFF :
                              clip_lo[i] ? 8'h00 : shifted[7:0];
  end

endmodule

// File: rtl/pxfmt_pack32.sv
module pxfmt_pack32 import pxfmt_pkg::*; #(
  parameter int LANES   = 2,
  parameter int LANE_W  = 32,
  parameter int BYTE_SH = 23,
  parameter int FIX_SH  = 16
) (
  input  logic [LANES*LANE_W-1:0] src_a,
  input  logic [LANES*LANE_W-1:0] src_b,
  input  logic [4:0]              scale,
  output logic [LANES*LANE_W-1:0] stream_out,
  output logic [LANES*16-1:0]     fix_out
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic signed [63:0] wide;
    logic [7:0]         byte_v;
    logic [15:0]        fix_v;
    logic               unused_top;

    assign wide   = 64'($signed(src_b[i*LANE_W +: LANE_W]));
    assign byte_v = clamp_u8(rescale(wide, scale, BYTE_SH));
    assign fix_v  = clamp_s16(rescale(wide, scale, FIX_SH));

    // First operand slides up one byte; the freed byte takes the packed pixel.
    assign stream_out[i*LANE_W +: LANE_W] = {src_a[i*LANE_W +: LANE_W-8], byte_v};
    assign fix_out[i*16 +: 16]            = fix_v;
    assign unused_top = ^src_a[i*LANE_W+LANE_W-8 +: 8];
  end

endmodule

// File: rtl/pxfmt_shuffle.sv
module pxfmt_shuffle #(
  parameter int BYTES = 4
) (
  input  logic [BYTES*8-1:0]  src_a,
  input  logic [BYTES*8-1:0]  src_b,
  output logic [BYTES*16-1:0] expand_out,
  output logic [BYTES*16-1:0] merge_out
);
  for (genvar k = 0; k < BYTES; k++) begin : g_byte
    assign expand_out[k*16 +: 16] = {4'h0, src_b[k*8 +: 8], 4'h0};
    assign merge_out[k*16 +: 16]  = {src_a[k*8 +: 8], src_b[k*8 +: 8]};
  end

endmodule

// File: rtl/pxfmt_unit.sv
module pxfmt_unit import pxfmt_pkg::*; #(
  parameter int DATA_W    = 64,
  parameter int OP_W      = 9,
  parameter int CTRL_W    = 8,
  parameter int SCALE_LSB = 3,
  parameter bit REG_OUT   = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [OP_W-1:0]   op_code,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [CTRL_W-1:0] fmt_ctrl,
  output logic              out_valid,
  output logic [DATA_W-1:0] result
);
  localparam int HALF_W  = DATA_W / 2;
  localparam int L16     = DATA_W / 16;
  localparam int L32     = DATA_W / 32;
  localparam int BYTES_H = HALF_W / 8;

  fmt_kind_e           sel_kind;
  logic                op_legal;
  logic                nxt_valid;
  logic [DATA_W-1:0]   nxt_result;
  logic [4:0]          scale5;
  logic [3:0]          scale4;
  logic [L16*8-1:0]    pk16;
  logic [L16-1:0]      clip16_hi;
  logic [L16-1:0]      clip16_lo;
  logic [DATA_W-1:0]   stream32;
  logic [L32*16-1:0]   fix32;
  logic [DATA_W-1:0]   expanded;
  logic [DATA_W-1:0]   merged;
  logic                unused_ctrl;

  assign scale5      = fmt_ctrl[SCALE_LSB +: 5];
  assign scale4      = fmt_ctrl[SCALE_LSB +: 4];
  assign unused_ctrl = ^fmt_ctrl[SCALE_LSB-1:0];

  always_comb begin
    case (op_code)
      OPC_PACK16:  sel_kind = K_PACK16;
      OPC_PACK32:  sel_kind = K_PACK32;
      OPC_PACKFIX: sel_kind = K_PACKFIX;
      OPC_EXPAND:  sel_kind = K_EXPAND;
      OPC_MERGE:   sel_kind = K_MERGE;
      default:     sel_kind = K_NONE;
    endcase
  end

  assign op_legal  = (sel_kind != K_NONE);
  assign nxt_valid = in_valid && op_legal;

  pxfmt_pack16 #(.LANES(L16), .LANE_W(16), .FRAC_SH(7)) i_pack16 (
    .src(src_b), .scale(scale4), .pk_out(pk16),
    .clip_hi(clip16_hi), .clip_lo(clip16_lo)
  );

  pxfmt_pack32 #(.LANES(L32), .LANE_W(32), .BYTE_SH(23), .FIX_SH(16)) i_pack32 (
    .src_a(src_a), .src_b(src_b), .scale(scale5),
    .stream_out(stream32), .fix_out(fix32)
  );

  pxfmt_shuffle #(.BYTES(BYTES_H)) i_shuffle (
    .src_a(src_a[HALF_W-1:0]), .src_b(src_b[HALF_W-1:0]),
    .expand_out(expanded), .merge_out(merged)
  );

  always_comb begin
    case (sel_kind)
      K_PACK16:  nxt_result = {{HALF_W{1'b0}}, pk16};
      K_PACK32:  nxt_result = stream32;
      K_PACKFIX: nxt_result = {{HALF_W{1'b0}}, fix32};
      K_EXPAND:  nxt_result = expanded;
      K_MERGE:   nxt_result = merged;
      default:   nxt_result = '0;
    endcase
  end

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        out_valid <= 1'b0;
        result    <= '0;
      end else begin
        out_valid <= nxt_valid;
        result    <= nxt_valid ? nxt_result : '0;
      end
    end
  end else begin : g_comb
    assign out_valid = nxt_valid;
    assign result    = nxt_valid ? nxt_result : '0;
  end

endmodule

// File: rtl/pxfmt_chk.sv
module pxfmt_chk import pxfmt_pkg::*; #(
  parameter int DATA_W  = 64,
  parameter int OP_W    = 9,
  parameter int L16     = 4,
  parameter bit REG_OUT = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [OP_W-1:0]   op_code,
  input logic [DATA_W-1:0] src_a,
  input logic              op_legal,
  input logic [L16-1:0]    clip16_hi,
  input logic [L16-1:0]    clip16_lo,
  input logic              out_valid,
  input logic [DATA_W-1:0] result
);
  assert_legal_codes_R1: assert property (@(posedge clk) disable iff (!rst_n)
    op_legal |-> (op_code == OPC_PACK16 || op_code == OPC_PACK32 ||
                  op_code == OPC_PACKFIX || op_code == OPC_EXPAND ||
                  op_code == OPC_MERGE));

  if (REG_OUT) begin : g_seq
    assert_illegal_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !op_legal) |=> (!out_valid && result == '0));

    assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(in_valid));

    assert_idle_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && result == '0));

    assert_narrow16_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(op_code) == OPC_PACK16) |-> result[63:32] == '0);

    assert_narrowfix_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(op_code) == OPC_PACKFIX) |-> result[63:32] == '0);

    assert_stream_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(op_code) == OPC_PACK32) |->
        (result[31:8] == $past(src_a[23:0]) && result[63:40] == $past(src_a[55:32])));

    assert_expand_nibbles_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(op_code) == OPC_EXPAND) |->
        (result & 64'hF00F_F00F_F00F_F00F) == '0);

    assert_clip_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(op_code == OPC_PACK16 && clip16_hi[0])) |-> result[7:0] == 8'hFF);

    assert_clip_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(op_code == OPC_PACK16 && clip16_lo[0])) |-> result[7:0] == 8'h00);

    assert_clip_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(clip16_hi[0] && clip16_lo[0]));

    assert_reset_clear_R11: assert property (@(posedge clk)
      !rst_n |=> (!out_valid && result == '0));
  end

endmodule

bind pxfmt_unit pxfmt_chk #(.DATA_W(DATA_W), .OP_W(OP_W), .L16(L16), .REG_OUT(REG_OUT)) i_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_code(op_code),
  .src_a(src_a), .op_legal(op_legal), .clip16_hi(clip16_hi),
  .clip16_lo(clip16_lo), .out_valid(out_valid), .result(result)
);

// File: tb/test_pxfmt_unit.sv
module test_pxfmt_unit;
  localparam logic [8:0] C_P16 = 9'h03B;
  localparam logic [8:0] C_P32 = 9'h03A;
  localparam logic [8:0] C_FIX = 9'h03D;
  localparam logic [8:0] C_EXP = 9'h04D;
  localparam logic [8:0] C_MRG = 9'h04B;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [8:0]  op_code = '0;
  logic [63:0] src_a = '0;
  logic [63:0] src_b = '0;
  logic [7:0]  fmt_ctrl = '0;
  logic        out_valid;
  logic [63:0] result;
  int n_vec = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  pxfmt_unit i_pxfmt_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_code(op_code),
    .src_a(src_a), .src_b(src_b), .fmt_ctrl(fmt_ctrl),
    .out_valid(out_valid), .result(result)
  );

  function automatic logic [15:0] pick16(input int k);
    case (k)
      0: return 16'h0000;  1: return 16'h0001;  2: return 16'h007F;
      3: return 16'h0080;  4: return 16'h00FF;  5: return 16'h0100;
      6: return 16'h7FFF;  7: return 16'h8000;  8: return 16'hFFFF;
      9: return 16'hFF80; 10: return 16'h1234; default: return 16'hC000;
    endcase
  endfunction

  function automatic logic [31:0] pick32(input int k);
    case (k)
      0: return 32'h0000_0000;  1: return 32'h0000_0001;  2: return 32'h007F_FFFF;
      3: return 32'h0080_0000;  4: return 32'h7FFF_FFFF;  5: return 32'h8000_0000;
      6: return 32'hFFFF_FFFF;  7: return 32'hFF80_0000;  8: return 32'h1234_5678;
      9: return 32'h0000_FFFF; 10: return 32'h0001_0000; default: return 32'hFFFF_0000;
    endcase
  endfunction

  function automatic longint ref_scale(input longint x, input int s, input int r);
    longint m;
    m = x * (longint'(1) << s);
    return m >>> r;
  endfunction

  function automatic logic [7:0] ref_u8(input longint x);
    if (x < 0) return 8'h00;
    if (x > 255) return 8'hFF;
    return x[7:0];
  endfunction

  function automatic logic [15:0] ref_s16(input longint x);
    if (x < -32768) return 16'h8000;
    if (x > 32767) return 16'h7FFF;
    return x[15:0];
  endfunction

  function automatic void ref_model(input logic [8:0] op, input logic [63:0] a,
                                    input logic [63:0] b, input logic [7:0] c,
                                    output logic v, output logic [63:0] r);
    r = '0;
    v = 1'b1;
    case (op)
      C_P16: for (int i = 0; i < 4; i++)
               r[8*i +: 8] = ref_u8(ref_scale(longint'($signed(b[16*i +: 16])), int'(c[6:3]), 7));
      C_P32: begin
        r = (a << 8) & ~64'h0000_00FF_0000_00FF;
        for (int i = 0; i < 2; i++)
          r[32*i +: 8] = ref_u8(ref_scale(longint'($signed(b[32*i +: 32])), int'(c[7:3]), 23));
      end
      C_FIX: for (int i = 0; i < 2; i++)
               r[16*i +: 16] = ref_s16(ref_scale(longint'($signed(b[32*i +: 32])), int'(c[7:3]), 16));
      C_EXP: for (int i = 0; i < 4; i++)
               r[16*i +: 16] = 16'(b[8*i +: 8]) * 16'd16;
      C_MRG: for (int i = 0; i < 4; i++) begin
               r[16*i +: 8]     = b[8*i +: 8];
               r[16*i + 8 +: 8] = a[8*i +: 8];
             end
      default: v = 1'b0;
    endcase
  endfunction

  // Called at a falling edge: drive, then compare at the next falling edge.
  task automatic apply(input logic iv, input logic [8:0] op, input logic [63:0] a,
                       input logic [63:0] b, input logic [7:0] c, input string req);
    logic ev;
    logic [63:0] er;
    in_valid = iv; op_code = op; src_a = a; src_b = b; fmt_ctrl = c;
    ref_model(op, a, b, c, ev, er);
    if (!iv) ev = 1'b0;
    if (!ev) er = '0;
    @(negedge clk);
    n_vec++;
    if (out_valid !== ev || result !== er) begin
      n_bad++;
      $display("FAIL %s op=%h ctrl=%h: actual v=%b r=%h expected v=%b r=%h",
               req, op, c, out_valid, result, ev, er);
    end
  endtask

  task automatic check_cleared(input string req);
    n_vec++;
    if (out_valid !== 1'b0 || result !== 64'h0) begin
      n_bad++;
      $display("FAIL %s: actual v=%b r=%h expected v=0 r=0", req, out_valid, result);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    // R11: held in reset with a live, legal request on the inputs
    in_valid = 1'b1; op_code = C_MRG; src_a = 64'h1111_2222_3333_4444;
    src_b = 64'h5555_6666_7777_8888; fmt_ctrl = 8'hFF;
    repeat (3) @(negedge clk);
    check_cleared("R11");
    rst_n = 1'b1;

    // R3 / R9: pack16 over every scale; junk in ctrl bit 7 and bits 2:0
    for (int s = 0; s < 16; s++)
      for (int k = 0; k < 12; k++)
        apply(1'b1, C_P16,
              {$urandom, $urandom},
              {pick16((k+3)%12), pick16((k+2)%12), pick16((k+1)%12), pick16(k)},
              {1'(k & 1), 4'(s), 3'b101},
              (s == 15) ? "R9 R3" : "R3");

    // R4 / R5 / R9: pack32 stream
    for (int s = 0; s < 32; s++)
      for (int k = 0; k < 12; k++)
        apply(1'b1, C_P32, {$urandom, $urandom},
              {pick32((k+5)%12), pick32(k)}, {5'(s), 3'(k)},
              (s == 31) ? "R9 R4 R5" : "R4 R5");

    // R6 / R9: packfix
    for (int s = 0; s < 32; s++)
      for (int k = 0; k < 12; k++)
        apply(1'b1, C_FIX, {$urandom, $urandom},
              {pick32(k), pick32((k+7)%12)}, {5'(s), 3'(k)},
              (s == 31) ? "R9 R6" : "R6");

    // R7: expand every byte value in every lane
    for (int v = 0; v < 256; v++)
      apply(1'b1, C_EXP, {$urandom, $urandom},
            {32'($urandom), 8'(v), 8'(255 - v), 8'(v ^ 90), 8'(v + 1)},
            8'($urandom), "R7");

    // R8: merge
    for (int n = 0; n < 64; n++)
      apply(1'b1, C_MRG, {$urandom, $urandom}, {$urandom, $urandom},
            8'($urandom), "R8");

    // R1 / R2: every operation code
    for (int op = 0; op < 512; op++)
      apply(1'b1, 9'(op), {$urandom, $urandom}, {$urandom, $urandom},
            8'($urandom), "R1 R2");

    // R10: one-cycle latency, then idle when in_valid drops
    apply(1'b1, C_MRG, 64'hA1B2_C3D4_E5F6_0718, 64'h1122_3344_5566_7788, 8'h00, "R10");
    apply(1'b0, C_MRG, 64'hA1B2_C3D4_E5F6_0718, 64'h1122_3344_5566_7788, 8'h00, "R10");
    apply(1'b1, C_EXP, 64'h0, 64'h0000_0000_FFFF_FFFF, 8'h00, "R10");

    // R11: reset asserted mid-stream wins over a valid request
    rst_n = 1'b0;
    in_valid = 1'b1; op_code = C_P32; src_a = 64'hFFFF_FFFF_FFFF_FFFF;
    src_b = 64'h7FFF_FFFF_7FFF_FFFF; fmt_ctrl = 8'hF8;
    @(negedge clk);
    check_cleared("R11");
    rst_n = 1'b1;
    apply(1'b1, C_P32, 64'hFFFF_FFFF_FFFF_FFFF, 64'h7FFF_FFFF_8000_0000, 8'hF8, "R11 R9");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule